// File: doc/BRIEF.md
# Serial Control Port with Register Readback

This block is a slave control port with four serial pins. A host moves 32-bit words in on a data pin, one bit per rising edge of a serial clock, and ends each word by raising a latch-enable pin. The low nibble of the word is the register address. Registers 1 to 6 hold control settings and are brought out in parallel to the rest of the chip. Register 0 is not stored. A word sent to register 0 is a command that can ask for one of the registers to be returned on a separate readback pin.

A readback has two phases. First the host writes a register-0 word with its enable flag set and a register index in it. The selected register is captured when latch enable rises. The first serial clock pulse after that is idle. Each of the next 32 pulses drives one bit onto the readback pin, starting with the LSB. A bit changes only just after a rising edge, so the host can sample it on the falling edge that follows. After the last bit the pin goes back low and the port leaves readback mode.

The serial pins are not clocked directly. Each pin passes through a two-flop synchroniser clocked by a system clock at least four times faster than the serial clock. Rising and falling edges are then found from the synchronised samples. Because of this, every output reacts a fixed few system cycles after the pin event that causes it.

Top module: `serreg_port`

## Requirements
- R1: After synchronous reset, all six parallel register outputs are zero and the readback pin is low.
- R2: Data is shifted in LSB first on each serial clock rising edge. When latch enable rises, the 32-bit word is written to the register whose number is in bits 2:0, provided that value is 1 to 6 and bit 3 is 0. Register 1 appears on bits 31:0 of the parallel output, register 2 on bits 63:32, and so on up to register 6.
- R3: A word whose low nibble is 7, or whose bit 3 is 1, changes no register.
- R4: A word addressed to register 0 (low nibble 0) leaves registers 1 to 6 unchanged. If its bit 31 is 1, it starts a readback of the register whose index is in bits 30:28.
- R5: During the first serial clock pulse after the latch-enable rise that starts a readback, the readback pin stays low.
- R6: On each of the 32 rising edges that follow the idle pulse, the next bit of the selected register is driven onto the readback pin, starting with bit 0. Each bit is held until the next rising edge.
- R7: A readback with index 0 or index 7 returns 32 zero bits.
- R8: On the serial clock falling edge that follows the 33rd pulse, the readback pin returns low and stays low on any further pulses until a new readback starts.
- R9: A register-0 word with bit 31 equal to 0 starts no readback, so the readback pin stays low.
- R10: If more than 32 bits are shifted in before latch enable rises, only the last 32 bits form the word.
- R11: With a system clock at least four times faster than the serial clock, a register output or the readback pin has taken its new value within four system cycles of the pin edge that caused the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_data | input | 1 | Serial write data, LSB first |
| ser_le | input | 1 | Latch enable; a rising edge ends a word |
| rb_out | output | 1 | Readback data pin |
| cfg_regs | output | 192 | Registers 1 to 6, with register n on bits 32n-1:32(n-1) |

## Verification
If the address decode is wrong, a neighbouring slice of the parallel output changes within four system cycles of the latch-enable rise, and the full-output comparison after each word catches it. Faults in the readback shifter or its counter show up on the readback pin. A slipped idle pulse or a wrong bit order gives a wrong bit already at the first or second sampled pulse. A wrong end count shows as a pin that is still active, or already quiet, around the 33rd pulse. Capture faults in the input shifter, such as keeping the first 32 bits instead of the last 32, appear only with overlong words. A dedicated overlong write exposes them on the next comparison.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int IDX_W     = 3;
    localparam int NUM_CTRL  = 6;
    localparam int CNT_W     = $clog2(WORD_W);
    localparam int PIN_COUNT = 3;   // clock, data, latch enable
    localparam int PIN_CLK   = 0;
    localparam int PIN_DAT   = 1;
    localparam int PIN_LE    = 2;

    typedef struct packed {
        logic                            rb_en;
        logic [IDX_W-1:0]                rb_idx;
        logic [WORD_W-ADDR_W-IDX_W-2:0]  body;
        logic [ADDR_W-1:0]               addr;
    } word_t;

    typedef enum logic [1:0] {RB_OFF, RB_IDLE, RB_SHIFT, RB_HOLD} rb_state_t;

    function automatic logic ctrl_hit(input logic [ADDR_W-1:0] a, input int n);
        return a == ADDR_W'(n);
    endfunction
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync
    import serreg_pkg::*;
#(
    parameter int N = PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [2:0] sh;   // [0],[1] synchroniser, [2] history for edge detect
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], pin[g]};
        end
        assign lvl[g]  = sh[1];
        assign rise[g] = sh[1] & ~sh[2];
        assign fall[g] = ~sh[1] & sh[2];
    end
endmodule

// File: rtl/serreg_shift_in.sv
module serreg_shift_in
    import serreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_rise,
    input  logic  sdata,
    input  logic  le_rise,
    output word_t word_q,
    output logic  commit
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            word_q <= '0;
            commit <= 1'b0;
        end else begin
            commit <= le_rise;
            if (sclk_rise) shreg <= {sdata, shreg[WORD_W-1:1]};
            if (le_rise)   word_q <= word_t'(shreg);
        end
    end
endmodule

// File: rtl/serreg_readback.sv
module serreg_readback
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              start,
    input  logic [WORD_W-1:0] load_val,
    output logic              rb_out,
    output logic              active
);
    rb_state_t         state;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RB_OFF;
            shreg  <= '0;
            cnt    <= '0;
            rb_out <= 1'b0;
        end else if (start) begin
            state  <= RB_IDLE;
            shreg  <= load_val;
            cnt    <= '0;
            rb_out <= 1'b0;
        end else begin
            unique case (state)
                RB_IDLE: if (sclk_rise) state <= RB_SHIFT;
                RB_SHIFT: if (sclk_rise) begin
                    rb_out <= shreg[0];
                    shreg  <= shreg >> 1;
                    cnt    <= cnt + 1'b1;
                    if (cnt == CNT_W'(WORD_W - 1)) state <= RB_HOLD;
                end
                RB_HOLD: if (sclk_fall) begin
                    state  <= RB_OFF;
                    rb_out <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign active = (state != RB_OFF);

    // R5
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RB_OFF || state == RB_IDLE) |-> !rb_out);
    // R8
    release_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RB_HOLD && sclk_fall && !start) |=> (state == RB_OFF && !rb_out));
    // R6
    shift_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RB_SHIFT && sclk_rise && !start) |=> rb_out == $past(shreg[0]));
endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_clk,
    input  logic                       ser_data,
    input  logic                       ser_le,
    output logic                       rb_out,
    output logic [NUM_CTRL*WORD_W-1:0] cfg_regs
);
    logic [PIN_COUNT-1:0] lvl, rise, fall;
    word_t                word_q;
    logic                 commit;
    logic [NUM_CTRL:1]    wr_en;
    logic                 rb_start, rb_active;
    logic [WORD_W-1:0]    rb_load;
    logic [WORD_W-1:0]    reg_q [1:NUM_CTRL];

    serreg_sync #(.N(PIN_COUNT)) u_sync (
        .clk(clk), .rst(rst), .pin({ser_le, ser_data, ser_clk}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    serreg_shift_in u_in (
        .clk(clk), .rst(rst), .sclk_rise(rise[PIN_CLK]), .sdata(lvl[PIN_DAT]),
        .le_rise(rise[PIN_LE]), .word_q(word_q), .commit(commit)
    );

    for (genvar i = 1; i <= NUM_CTRL; i++) begin : g_reg
        assign wr_en[i] = commit && ctrl_hit(word_q.addr, i);
        always_ff @(posedge clk) begin
            if (rst)           reg_q[i] <= '0;
            else if (wr_en[i]) reg_q[i] <= word_q;
        end
        assign cfg_regs[(i-1)*WORD_W +: WORD_W] = reg_q[i];

        // R2
        reg_write_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |=> cfg_regs[(i-1)*WORD_W +: WORD_W] == $past(word_q));
    end

    assign rb_start = commit && ctrl_hit(word_q.addr, 0) && word_q.rb_en;

    always_comb begin
        rb_load = '0;
        for (int k = 1; k <= NUM_CTRL; k++)
            if (word_q.rb_idx == IDX_W'(k)) rb_load = reg_q[k];
    end

    serreg_readback u_rb (
        .clk(clk), .rst(rst), .sclk_rise(rise[PIN_CLK]), .sclk_fall(fall[PIN_CLK]),
        .start(rb_start), .load_val(rb_load), .rb_out(rb_out), .active(rb_active)
    );

    // R3
    ignored_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && wr_en == '0) |=> $stable(cfg_regs));
    // R4
    rb_enter_chk: assert property (@(posedge clk) disable iff (rst)
        rb_start |=> rb_active);
endmodule

// File: tb/tb_serreg_port.sv
module tb_serreg_port;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic         rb_out;
    logic [191:0] cfg_regs;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_regs [1:6];
    logic [31:0] model_rb;

    always #10 clk = ~clk;   // 50 MHz

    serreg_port dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .rb_out(rb_out), .cfg_regs(cfg_regs)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial pulse; returns rb_out sampled at end of high phase
    task automatic pulse(input logic d, output logic sampled);
        ser_data = d;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        sampled = rb_out;
        ser_clk = 1'b0;
    endtask

    task automatic check_regs(input string req);
        for (int i = 1; i <= 6; i++)
            chk(cfg_regs[(i-1)*32 +: 32] === model_regs[i], req,
                cfg_regs[(i-1)*32 +: 32], model_regs[i]);
    endtask

    task automatic write_word(input logic [31:0] w, input int junk);
        logic s;
        for (int j = 0; j < junk; j++) pulse(1'(j % 3 == 0), s);
        for (int b = 0; b < 32; b++) pulse(w[b], s);
        wait_n(4);
        ser_le = 1'b1;
        wait_n(8);
        ser_le = 1'b0;
        wait_n(4);
        if (w[3] == 1'b0 && w[2:0] >= 3'd1 && w[2:0] <= 3'd6) model_regs[w[2:0]] = w;
        if (w[3:0] == 4'd0 && w[31])
            model_rb = (w[30:28] >= 3'd1 && w[30:28] <= 3'd6) ? model_regs[w[30:28]] : 32'h0;
    endtask

    // 33 pulses plus one extra; compare against expected stream
    task automatic read_back(input logic [31:0] exp, input string req);
        logic s;
        pulse(1'b0, s);
        chk(s === 1'b0, "R5", {31'b0, s}, 32'h0);
        for (int k = 0; k < 32; k++) begin
            pulse(1'b0, s);
            chk(s === exp[k], req, {31'b0, s}, {31'b0, exp[k]});
            if (k < 31) begin
                wait_n(4);
                chk(rb_out === exp[k], "R6 hold", {31'b0, rb_out}, {31'b0, exp[k]});
            end
        end
        wait_n(5);
        chk(rb_out === 1'b0, "R8 release", {31'b0, rb_out}, 32'h0);
        pulse(1'b1, s);
        chk(s === 1'b0, "R8 extra pulse", {31'b0, s}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic s;
        for (int i = 1; i <= 6; i++) model_regs[i] = 32'h0;
        model_rb = 32'h0;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R1
        check_regs("R1");
        chk(rb_out === 1'b0, "R1 rb", {31'b0, rb_out}, 32'h0);

        // R2 and R11: writes sampled within a few cycles of latch rise
        write_word(32'h1234_5671, 0); check_regs("R2 reg1");
        write_word(32'hCAFE_BAB6, 0); check_regs("R2 reg6");
        write_word(32'h8000_0003, 0); check_regs("R11 reg3");
        write_word(32'h5A5A_C3C5, 0); check_regs("R2 reg5");

        // R3: address 7 and bit3 set are ignored
        write_word(32'hFFFF_FFF7, 0); check_regs("R3 addr7");
        write_word(32'hDEAD_BEE9, 0); check_regs("R3 bit3");

        // R10: overlong word keeps last 32 bits
        write_word(32'h0F0F_0F02, 8); check_regs("R10");

        // R9 and R4: register 0 without enable
        write_word(32'h3000_0000, 0); check_regs("R4 no change");
        for (int k = 0; k < 34; k++) begin
            pulse(1'b0, s);
            chk(s === 1'b0, "R9", {31'b0, s}, 32'h0);
        end

        // R6: readback of register 6, then 1, then 3
        write_word(32'hE000_0000, 0); check_regs("R4 rb6");
        read_back(model_rb, "R6 reg6");
        write_word(32'h9000_0000, 0);
        read_back(model_rb, "R6 reg1");
        write_word(32'hB000_0000, 0);
        read_back(model_rb, "R6 reg3");

        // R7: index 7 and index 0 return zeros
        write_word(32'hF000_0000, 0);
        read_back(32'h0, "R7 idx7");
        write_word(32'h8000_0000, 0);
        read_back(32'h0, "R7 idx0");
        check_regs("R4 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule